// File: doc/BRIEF.md
# BCH Error-Locator Job Status Controller

This block is the register and status front end of an eight-slot error-location engine for BCH-coded flash sectors. Software loads a 208-bit syndrome into a slot through a 32-bit register port and marks it ready. An external decode core, which does the Galois-field arithmetic and is not part of this block, picks up ready slots. For each slot it hands back a correctable flag, an error count and sixteen 13-bit error bit addresses. The block latches these results into read-only registers and marks the slot finished. Software clears a finished mark by writing 1 to it.

Any subset of slots can be grouped into a page. A page-complete flag rises when every slot of the group has finished. A continuous mode turns page grouping off. One interrupt line combines all status flags, each gated by its own enable bit.

The register port is a plain write strobe with address and data. The read data follows the address combinationally.

Top module: `errloc_job_ctrl`

## Requirements
- R1: After reset, every register reads 0 and `irq_o` and `job_valid_o` are low. This covers status, enable, configuration, page select, all syndrome fragments and all result registers.
- R2: Syndrome fragment f (0..6) of slot s sits at byte address 0x400 + 0x40*s + 4*f. Fragments 0..5 store all 32 bits. Fragment 6 stores only bits 15:0, which hold syndrome bits 207:192, and its other data bits read 0.
- R3: Writing fragment 6 with bit 16 set raises `job_valid_o[s]` after that clock edge, and the fragment reads bit 16 back as 1. `core_syn_o` carries the 208-bit syndrome of slot `core_slot_i`, with fragment f in bits 32*f upward.
- R4: A result pulse (`res_valid_i` with `res_slot_i` = s, while slot s is ready) is taken at one edge. At that edge the block stores the correctable flag in bit 8 and the count in bits 4:0 of 0x800 + 0x100*s. It stores error address k in bits 12:0 of 0x840 + 0x100*s + 4*k. At the same edge the slot's ready bit drops and status bit s sets.
- R5: A result pulse for a slot whose ready bit is clear is ignored. Status and result registers keep their values.
- R6: The status register at 0x000 holds one finished bit per slot in bits 7:0 and the page-complete bit in bit 8. Writing 1 to a bit clears it. Writing 0 leaves it unchanged.
- R7: If a write clears a finished bit in the same cycle that a new result sets it, the bit ends up set.
- R8: The page-complete bit sets one edge after the selected slots first become all finished, and only when the effective selection is non-zero. It sets once per such event, so clearing it while the slots stay finished does not raise it again. It never sets while the effective selection is zero.
- R9: The page-select register at 0x00C (bits 7:0) reads back what was written. While the continuous-mode bit (bit 4 of the configuration register) is 1, the effective selection is zero. Once continuous mode is turned off, a selection that is already all finished counts as a new event.
- R10: The enable register at 0x004 holds bits 8:0, one per status bit. `irq_o` is high exactly when some status bit and its enable bit are both 1, and it follows register changes in the same cycle.
- R11: The configuration register at 0x008 holds the buffer size in nibbles in bits 26:16, continuous mode in bit 4 and the correction level in bits 1:0. The size and level drive `cfg_size_o` and `cfg_level_o`, and all other bits read 0.
- R12: Reads from any other address return 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 12 | Byte address of the register access |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i`, combinational |
| job_valid_o | output | 8 | Per-slot syndrome-ready flags |
| core_slot_i | input | 3 | Slot whose syndrome the decode core reads |
| core_syn_o | output | 208 | Syndrome of slot `core_slot_i` |
| res_valid_i | input | 1 | Result pulse from the decode core |
| res_slot_i | input | 3 | Slot the result belongs to |
| res_ok_i | input | 1 | Result correctable flag |
| res_cnt_i | input | 5 | Number of located errors |
| res_loc_i | input | 208 | Sixteen 13-bit error addresses, entry k in bits 13*k upward |
| cfg_size_o | output | 11 | Configured buffer size in nibbles |
| cfg_level_o | output | 2 | Configured correction level |
| irq_o | output | 1 | Masked interrupt |

## Verification
Each result is due at a fixed point:
- Register writes and result pulses take effect at the next rising edge. Stored fields, finished bits and the dropped ready bit are all visible right after that edge.
- The page-complete bit appears one edge later than the finished bit that completes the page.
- `irq_o` and read data follow their registers within the same cycle.

The bench drives inputs and samples outputs on falling edges. Page checks read the status once right after the completing result, expecting no page bit, and again one cycle later, expecting it set. This pins the extra register stage. The decode-core model waits a random number of cycles before each result pulse, so no check depends on a fixed schedule.

// File: rtl/errloc_pkg.sv
package errloc_pkg;
  localparam int unsigned REG_W        = 32;
  localparam int unsigned ADDR_W       = 12;
  localparam int unsigned VALID_BIT    = 16;
  localparam int unsigned OK_BIT       = 8;
  localparam int unsigned CFG_SIZE_LSB = 16;
  localparam int unsigned CFG_CONT_BIT = 4;

  typedef enum logic [1:0] {
    CTL_STATUS = 2'd0,
    CTL_ENABLE = 2'd1,
    CTL_CONFIG = 2'd2,
    CTL_PAGE   = 2'd3
  } ctl_reg_e;
endpackage

// File: rtl/errloc_syn_bank.sv
module errloc_syn_bank
  import errloc_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 8,
  parameter int unsigned SYN_W     = 208
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         wr_en_i,
  input  logic [$clog2(NUM_SLOTS)-1:0] wr_slot_i,
  input  logic [$clog2((SYN_W+31)/32)-1:0] wr_frag_i,
  input  logic [REG_W-1:0]             wr_data_i,
  input  logic [NUM_SLOTS-1:0]         clr_i,
  input  logic [$clog2(NUM_SLOTS)-1:0] rd_slot_i,
  input  logic [$clog2((SYN_W+31)/32)-1:0] rd_frag_i,
  output logic [REG_W-1:0]             rd_data_o,
  input  logic [$clog2(NUM_SLOTS)-1:0] core_slot_i,
  output logic [SYN_W-1:0]             core_syn_o,
  output logic [NUM_SLOTS-1:0]         valid_o
);
  localparam int unsigned FRAG_N = (SYN_W + 31) / 32;
  localparam int unsigned TAIL_W = SYN_W - 32 * (FRAG_N - 1);
  localparam int unsigned SLOT_W = $clog2(NUM_SLOTS);
  localparam int unsigned FRAG_W = $clog2(FRAG_N);
  localparam logic [REG_W-1:0] TAIL_KEEP = REG_W'((64'd1 << TAIL_W) - 64'd1);

  logic [REG_W-1:0]     frag_q [NUM_SLOTS][FRAG_N];
  logic [NUM_SLOTS-1:0] valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < NUM_SLOTS; s++)
        for (int f = 0; f < FRAG_N; f++) frag_q[s][f] <= '0;
    end else if (wr_en_i) begin
      for (int s = 0; s < NUM_SLOTS; s++)
        for (int f = 0; f < FRAG_N; f++)
          if (wr_slot_i == SLOT_W'(s) && wr_frag_i == FRAG_W'(f))
            frag_q[s][f] <= (f == FRAG_N - 1) ? (wr_data_i & TAIL_KEEP) : wr_data_i;
    end
  end

  // completion clear outranks a software write of the ready bit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
    end else begin
      for (int s = 0; s < NUM_SLOTS; s++) begin
        if (clr_i[s])
          valid_q[s] <= 1'b0;
        else if (wr_en_i && wr_slot_i == SLOT_W'(s) && wr_frag_i == FRAG_W'(FRAG_N - 1))
          valid_q[s] <= wr_data_i[VALID_BIT];
      end
    end
  end

  always_comb begin
    rd_data_o = '0;
    if ({1'b0, rd_frag_i} < (FRAG_W + 1)'(FRAG_N)) rd_data_o = frag_q[rd_slot_i][rd_frag_i];
    if (rd_frag_i == FRAG_W'(FRAG_N - 1)) rd_data_o[VALID_BIT] = valid_q[rd_slot_i];
  end

  for (genvar f = 0; f < FRAG_N; f++) begin : g_syn
    if (f < FRAG_N - 1) begin : g_full
      assign core_syn_o[f*32 +: 32] = frag_q[core_slot_i][f];
    end else begin : g_tail
      assign core_syn_o[SYN_W-1:f*32] = frag_q[core_slot_i][f][TAIL_W-1:0];
    end
  end

  assign valid_o = valid_q;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_chk
    p_ready_drops_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i[s] |=> !valid_o[s]);
  end
endmodule

// File: rtl/errloc_result_bank.sv
module errloc_result_bank
  import errloc_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 8,
  parameter int unsigned NUM_LOCS  = 16,
  parameter int unsigned LOC_W     = 13,
  parameter int unsigned CNT_W     = 5
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [NUM_SLOTS-1:0]          cap_i,
  input  logic                          ok_i,
  input  logic [CNT_W-1:0]              cnt_i,
  input  logic [NUM_LOCS*LOC_W-1:0]     loc_i,
  input  logic [$clog2(NUM_SLOTS)-1:0]  rd_slot_i,
  input  logic                          rd_loc_i,
  input  logic [$clog2(NUM_LOCS)-1:0]   rd_idx_i,
  output logic [REG_W-1:0]              rd_data_o
);
  logic [NUM_SLOTS-1:0] ok_q;
  logic [CNT_W-1:0]     cnt_q [NUM_SLOTS];
  logic [LOC_W-1:0]     loc_q [NUM_SLOTS][NUM_LOCS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ok_q <= '0;
      for (int s = 0; s < NUM_SLOTS; s++) begin
        cnt_q[s] <= '0;
        for (int k = 0; k < NUM_LOCS; k++) loc_q[s][k] <= '0;
      end
    end else begin
      for (int s = 0; s < NUM_SLOTS; s++) begin
        if (cap_i[s]) begin
          ok_q[s]  <= ok_i;
          cnt_q[s] <= cnt_i;
          for (int k = 0; k < NUM_LOCS; k++) loc_q[s][k] <= loc_i[k*LOC_W +: LOC_W];
        end
      end
    end
  end

  always_comb begin
    rd_data_o = '0;
    if (rd_loc_i) begin
      rd_data_o[LOC_W-1:0] = loc_q[rd_slot_i][rd_idx_i];
    end else begin
      rd_data_o[OK_BIT]    = ok_q[rd_slot_i];
      rd_data_o[CNT_W-1:0] = cnt_q[rd_slot_i];
    end
  end

  p_single_capture_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(cap_i));
endmodule

// File: rtl/errloc_status.sv
module errloc_status #(
  parameter int unsigned NUM_SLOTS = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_SLOTS-1:0] done_set_i,
  input  logic                 clr_wr_i,
  input  logic [NUM_SLOTS:0]   clr_data_i,
  input  logic [NUM_SLOTS:0]   en_i,
  input  logic [NUM_SLOTS-1:0] sel_eff_i,
  output logic [NUM_SLOTS:0]   status_o,
  output logic                 irq_o
);
  localparam int unsigned PG = NUM_SLOTS;

  logic [NUM_SLOTS-1:0] done_q, clr_mask;
  logic page_q, hit, hit_q, page_set, page_clr;

  assign clr_mask = clr_wr_i ? clr_data_i[NUM_SLOTS-1:0] : '0;
  assign page_clr = clr_wr_i & clr_data_i[PG];
  assign hit      = (sel_eff_i != '0) && ((done_q & sel_eff_i) == sel_eff_i);
  assign page_set = hit & ~hit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q <= '0;
      page_q <= 1'b0;
      hit_q  <= 1'b0;
    end else begin
      done_q <= done_set_i | (done_q & ~clr_mask);
      page_q <= page_set | (page_q & ~page_clr);
      hit_q  <= hit;
    end
  end

  assign status_o = {page_q, done_q};
  assign irq_o    = |(status_o & en_i);

  p_set_wins_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_set_i != '0) |=>
      ((status_o[NUM_SLOTS-1:0] & $past(done_set_i)) == $past(done_set_i)));
  p_zero_write_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_wr_i && clr_data_i == '0 && done_set_i == '0) |=> $stable(status_o[NUM_SLOTS-1:0]));
  p_page_needs_sel_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_o[PG]) |-> $past(sel_eff_i != '0));
  p_irq_masked_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i == '0) |-> !irq_o);
endmodule

// File: rtl/errloc_job_ctrl.sv
module errloc_job_ctrl
  import errloc_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 8,
  parameter int unsigned SYN_W     = 208,
  parameter int unsigned NUM_LOCS  = 16,
  parameter int unsigned LOC_W     = 13,
  parameter int unsigned CNT_W     = 5,
  parameter int unsigned SIZE_W    = 11,
  parameter int unsigned LVL_W     = 2
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          reg_we_i,
  input  logic [ADDR_W-1:0]             reg_addr_i,
  input  logic [REG_W-1:0]              reg_wdata_i,
  output logic [REG_W-1:0]              reg_rdata_o,
  output logic [NUM_SLOTS-1:0]          job_valid_o,
  input  logic [$clog2(NUM_SLOTS)-1:0]  core_slot_i,
  output logic [SYN_W-1:0]              core_syn_o,
  input  logic                          res_valid_i,
  input  logic [$clog2(NUM_SLOTS)-1:0]  res_slot_i,
  input  logic                          res_ok_i,
  input  logic [CNT_W-1:0]              res_cnt_i,
  input  logic [NUM_LOCS*LOC_W-1:0]     res_loc_i,
  output logic [SIZE_W-1:0]             cfg_size_o,
  output logic [LVL_W-1:0]              cfg_level_o,
  output logic                          irq_o
);
  localparam int unsigned SLOT_W   = $clog2(NUM_SLOTS);
  localparam int unsigned FRAG_N   = (SYN_W + 31) / 32;
  localparam int unsigned FRAG_W   = $clog2(FRAG_N);
  localparam int unsigned IDX_W    = $clog2(NUM_LOCS);
  localparam int unsigned SYN_SLOT_LSB = 6;  // 0x40 per slot
  localparam int unsigned RES_SLOT_LSB = 8;  // 0x100 per slot

  // address decode
  logic     aligned, ctl_hit, syn_hit, res_hit, res_stat_hit, res_loc_hit;
  ctl_reg_e ctl_sel;
  logic [7:0] res_off;

  assign aligned      = reg_addr_i[1:0] == 2'b00;
  assign ctl_hit      = aligned && reg_addr_i[ADDR_W-1:4] == '0;
  assign ctl_sel      = ctl_reg_e'(reg_addr_i[3:2]);
  assign syn_hit      = aligned && reg_addr_i[11:9] == 3'b010 && !reg_addr_i[5]
                        && ({1'b0, reg_addr_i[2 +: FRAG_W]} < (FRAG_W + 1)'(FRAG_N));
  assign res_hit      = aligned && reg_addr_i[11];
  assign res_off      = reg_addr_i[7:0];
  assign res_stat_hit = res_hit && res_off == 8'h00;
  assign res_loc_hit  = res_hit && res_off[7:6] == 2'b01;

  // control registers
  logic [NUM_SLOTS:0]   en_q;
  logic [NUM_SLOTS-1:0] page_sel_q, sel_eff;
  logic [SIZE_W-1:0]    size_q;
  logic [LVL_W-1:0]     lvl_q;
  logic                 cont_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q       <= '0;
      page_sel_q <= '0;
      size_q     <= '0;
      lvl_q      <= '0;
      cont_q     <= 1'b0;
    end else if (reg_we_i && ctl_hit) begin
      case (ctl_sel)
        CTL_ENABLE: en_q <= reg_wdata_i[NUM_SLOTS:0];
        CTL_CONFIG: begin
          size_q <= reg_wdata_i[CFG_SIZE_LSB +: SIZE_W];
          lvl_q  <= reg_wdata_i[LVL_W-1:0];
          cont_q <= reg_wdata_i[CFG_CONT_BIT];
        end
        CTL_PAGE:   page_sel_q <= reg_wdata_i[NUM_SLOTS-1:0];
        default:    ;
      endcase
    end
  end

  assign sel_eff     = cont_q ? '0 : page_sel_q;
  assign cfg_size_o  = size_q;
  assign cfg_level_o = lvl_q;

  // result acceptance: only for a slot that is ready
  logic                 res_fire;
  logic [NUM_SLOTS-1:0] cap;
  assign res_fire = res_valid_i && job_valid_o[res_slot_i];
  assign cap      = res_fire ? (NUM_SLOTS'(1) << res_slot_i) : '0;

  logic [REG_W-1:0]   syn_rd, res_rd;
  logic [NUM_SLOTS:0] status;

  errloc_syn_bank #(.NUM_SLOTS(NUM_SLOTS), .SYN_W(SYN_W)) u_syn (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (reg_we_i && syn_hit),
    .wr_slot_i   (reg_addr_i[SYN_SLOT_LSB +: SLOT_W]),
    .wr_frag_i   (reg_addr_i[2 +: FRAG_W]),
    .wr_data_i   (reg_wdata_i),
    .clr_i       (cap),
    .rd_slot_i   (reg_addr_i[SYN_SLOT_LSB +: SLOT_W]),
    .rd_frag_i   (reg_addr_i[2 +: FRAG_W]),
    .rd_data_o   (syn_rd),
    .core_slot_i (core_slot_i),
    .core_syn_o  (core_syn_o),
    .valid_o     (job_valid_o)
  );

  errloc_result_bank #(.NUM_SLOTS(NUM_SLOTS), .NUM_LOCS(NUM_LOCS), .LOC_W(LOC_W),
                       .CNT_W(CNT_W)) u_res (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cap_i     (cap),
    .ok_i      (res_ok_i),
    .cnt_i     (res_cnt_i),
    .loc_i     (res_loc_i),
    .rd_slot_i (reg_addr_i[RES_SLOT_LSB +: SLOT_W]),
    .rd_loc_i  (res_loc_hit),
    .rd_idx_i  (reg_addr_i[2 +: IDX_W]),
    .rd_data_o (res_rd)
  );

  errloc_status #(.NUM_SLOTS(NUM_SLOTS)) u_stat (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .done_set_i (cap),
    .clr_wr_i   (reg_we_i && ctl_hit && ctl_sel == CTL_STATUS),
    .clr_data_i (reg_wdata_i[NUM_SLOTS:0]),
    .en_i       (en_q),
    .sel_eff_i  (sel_eff),
    .status_o   (status),
    .irq_o      (irq_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    if (ctl_hit) begin
      case (ctl_sel)
        CTL_STATUS: reg_rdata_o[NUM_SLOTS:0] = status;
        CTL_ENABLE: reg_rdata_o[NUM_SLOTS:0] = en_q;
        CTL_CONFIG: begin
          reg_rdata_o[CFG_SIZE_LSB +: SIZE_W] = size_q;
          reg_rdata_o[CFG_CONT_BIT]           = cont_q;
          reg_rdata_o[LVL_W-1:0]              = lvl_q;
        end
        default:    reg_rdata_o[NUM_SLOTS-1:0] = page_sel_q;
      endcase
    end else if (syn_hit) begin
      reg_rdata_o = syn_rd;
    end else if (res_stat_hit || res_loc_hit) begin
      reg_rdata_o = res_rd;
    end
  end

  p_cont_blocks_page_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cont_q |=> !$rose(status[NUM_SLOTS]));
endmodule

// File: tb/tb_errloc_job_ctrl.sv
module tb_errloc_job_ctrl;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         reg_we = 1'b0;
  logic [11:0]  reg_addr = '0;
  logic [31:0]  reg_wdata = '0;
  logic [31:0]  reg_rdata;
  logic [7:0]   job_valid;
  logic [2:0]   core_slot = '0;
  logic [207:0] core_syn;
  logic         res_valid = 1'b0;
  logic [2:0]   res_slot = '0;
  logic         res_ok = 1'b0;
  logic [4:0]   res_cnt = '0;
  logic [207:0] res_loc = '0;
  logic [10:0]  cfg_size;
  logic [1:0]   cfg_level;
  logic         irq;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  errloc_job_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .job_valid_o(job_valid),
    .core_slot_i(core_slot), .core_syn_o(core_syn), .res_valid_i(res_valid),
    .res_slot_i(res_slot), .res_ok_i(res_ok), .res_cnt_i(res_cnt), .res_loc_i(res_loc),
    .cfg_size_o(cfg_size), .cfg_level_o(cfg_level), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic rd_chk(input string tag, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(tag, d, exp);
  endtask

  function automatic logic [11:0] syn_addr(input int s, input int f);
    return 12'(12'h400 + s * 12'h40 + f * 4);
  endfunction

  function automatic logic [11:0] res_addr(input int s);
    return 12'(12'h800 + s * 12'h100);
  endfunction

  function automatic logic [11:0] loc_addr(input int s, input int k);
    return 12'(12'h840 + s * 12'h100 + k * 4);
  endfunction

  task automatic arm(input int s);
    wr(syn_addr(s, 6), 32'h0001_0000);
  endtask

  // decode-core model: random latency, then one result pulse
  task automatic core_return(input int s, input logic ok, input logic [4:0] cnt,
                             input logic [12:0] base);
    repeat ($urandom_range(0, 4)) @(negedge clk);
    res_valid = 1'b1; res_slot = 3'(s); res_ok = ok; res_cnt = cnt;
    for (int k = 0; k < 16; k++) res_loc[k*13 +: 13] = 13'(base + 13'(k));
    @(negedge clk);
    res_valid = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 irq", {31'd0, irq}, 0);
    chk("R1 job_valid", {24'd0, job_valid}, 0);
    rd_chk("R1 status", 12'h000, 0);
    rd_chk("R1 enable", 12'h004, 0);
    rd_chk("R1 config", 12'h008, 0);
    rd_chk("R1 page", 12'h00C, 0);
    rd_chk("R1 syndrome", syn_addr(3, 6), 0);
    rd_chk("R1 result", res_addr(5), 0);
    rd_chk("R1 location", loc_addr(5, 9), 0);
  endtask

  task automatic t_syndrome_and_result;
    logic [207:0] exp_syn;
    for (int f = 0; f < 6; f++) begin
      logic [31:0] v = 32'hA500_0000 ^ (32'h0103_0507 * (f + 1));
      wr(syn_addr(2, f), v);
      exp_syn[f*32 +: 32] = v;
    end
    wr(syn_addr(2, 6), 32'hFFFF_1234);
    exp_syn[207:192] = 16'h1234;
    for (int f = 0; f < 6; f++) rd_chk("R2 fragment readback", syn_addr(2, f), exp_syn[f*32 +: 32]);
    rd_chk("R2 R3 tail fragment with ready bit", syn_addr(2, 6), 32'h0001_1234);
    chk("R3 job_valid", {24'd0, job_valid}, 32'h04);
    core_slot = 3'd2;
    #1;
    for (int f = 0; f < 7; f++) chk("R3 core_syn slice", core_syn[f*32 +: 32],
                                   (f == 6) ? {16'd0, exp_syn[207:192]} : exp_syn[f*32 +: 32]);
    core_return(2, 1'b1, 5'd5, 13'h100);
    rd_chk("R4 status bit 2", 12'h000, 32'h004);
    rd_chk("R4 result word", res_addr(2), 32'h105);
    rd_chk("R4 location 0", loc_addr(2, 0), 32'h100);
    rd_chk("R4 location 15", loc_addr(2, 15), 32'h10F);
    chk("R4 ready dropped", {24'd0, job_valid}, 0);
    rd_chk("R4 tail ready bit cleared", syn_addr(2, 6), 32'h0000_1234);
  endtask

  task automatic t_ignore;
    core_return(5, 1'b1, 5'd3, 13'h0AA);
    repeat (2) @(negedge clk);
    rd_chk("R5 status unchanged", 12'h000, 32'h004);
    rd_chk("R5 result untouched", res_addr(5), 0);
    rd_chk("R5 location untouched", loc_addr(5, 1), 0);
  endtask

  task automatic t_w1c;
    wr(12'h000, 32'h000);
    rd_chk("R6 zero write keeps bit", 12'h000, 32'h004);
    wr(12'h000, 32'h001);
    rd_chk("R6 other bit write keeps bit", 12'h000, 32'h004);
    wr(12'h000, 32'h004);
    rd_chk("R6 one clears bit", 12'h000, 0);
  endtask

  task automatic t_set_wins;
    arm(1);
    core_return(1, 1'b0, 5'd0, 13'h0);
    rd_chk("R7 first completion", 12'h000, 32'h002);
    arm(1);
    @(negedge clk);
    res_valid = 1'b1; res_slot = 3'd1; res_ok = 1'b1; res_cnt = 5'd2;
    reg_we = 1'b1; reg_addr = 12'h000; reg_wdata = 32'h002;
    @(negedge clk);
    res_valid = 1'b0; reg_we = 1'b0;
    rd_chk("R7 set beats clear", 12'h000, 32'h002);
    rd_chk("R7 new result stored", res_addr(1), 32'h102);
  endtask

  task automatic t_page;
    wr(12'h000, 32'h1FF);
    wr(12'h00C, 32'h0B);
    arm(0); arm(1); arm(3);
    core_return(0, 1'b1, 5'd1, 13'h10);
    core_return(1, 1'b1, 5'd1, 13'h20);
    rd_chk("R8 partial page", 12'h000, 32'h003);
    core_return(3, 1'b1, 5'd1, 13'h30);
    rd_chk("R8 page not yet", 12'h000, 32'h00B);
    @(negedge clk);
    rd_chk("R8 page one cycle later", 12'h000, 32'h10B);
    wr(12'h000, 32'h100);
    repeat (3) @(negedge clk);
    rd_chk("R8 page sets once per event", 12'h000, 32'h00B);
    wr(12'h000, 32'h1FF);
    wr(12'h00C, 32'h80);
    arm(7);
    core_return(7, 1'b0, 5'd0, 13'h0);
    @(negedge clk);
    rd_chk("R8 single-slot page", 12'h000, 32'h180);
    wr(12'h000, 32'h1FF);
    wr(12'h00C, 32'h00);
    arm(4);
    core_return(4, 1'b0, 5'd0, 13'h0);
    repeat (2) @(negedge clk);
    rd_chk("R8 empty selection never pages", 12'h000, 32'h010);
  endtask

  task automatic t_continuous;
    wr(12'h000, 32'h1FF);
    wr(12'h00C, 32'h03);
    wr(12'h008, 32'h10);
    arm(0); arm(1);
    core_return(0, 1'b1, 5'd0, 13'h0);
    core_return(1, 1'b1, 5'd0, 13'h0);
    repeat (2) @(negedge clk);
    rd_chk("R9 continuous blocks page", 12'h000, 32'h003);
    rd_chk("R9 page select reads stored", 12'h00C, 32'h03);
    wr(12'h008, 32'h00);
    rd_chk("R9 page follows one cycle after mode off", 12'h000, 32'h003);
    @(negedge clk);
    rd_chk("R9 page after mode off", 12'h000, 32'h103);
    wr(12'h000, 32'h1FF);
    wr(12'h00C, 32'h00);
  endtask

  task automatic t_irq;
    wr(12'h004, 32'h000);
    arm(6);
    core_return(6, 1'b1, 5'd0, 13'h0);
    chk("R10 masked irq low", {31'd0, irq}, 0);
    wr(12'h004, 32'h040);
    chk("R10 enabled irq high", {31'd0, irq}, 1);
    rd_chk("R10 enable readback", 12'h004, 32'h040);
    wr(12'h004, 32'h1BF);
    chk("R10 other enables irq low", {31'd0, irq}, 0);
    wr(12'h004, 32'h040);
    wr(12'h000, 32'h040);
    chk("R10 irq low after clear", {31'd0, irq}, 0);
    wr(12'h004, 32'h100);
    wr(12'h00C, 32'h40);
    arm(6);
    core_return(6, 1'b1, 5'd0, 13'h0);
    chk("R10 page irq not yet", {31'd0, irq}, 0);
    @(negedge clk);
    chk("R10 page irq", {31'd0, irq}, 1);
    wr(12'h000, 32'h1FF);
    wr(12'h00C, 32'h00);
    wr(12'h004, 32'h000);
  endtask

  task automatic t_config;
    wr(12'h008, 32'hFFFF_FFFF);
    rd_chk("R11 config readback", 12'h008, 32'h07FF_0013);
    chk("R11 size out", {21'd0, cfg_size}, 32'h7FF);
    chk("R11 level out", {30'd0, cfg_level}, 32'h3);
    wr(12'h008, 32'h0123_0002);
    chk("R11 size value", {21'd0, cfg_size}, 32'h123);
    chk("R11 level value", {30'd0, cfg_level}, 32'h2);
    wr(12'h008, 32'h0);
  endtask

  task automatic t_unlisted;
    wr(12'h010, 32'hFFFF_FFFF);
    wr(12'h41C, 32'hFFFF_FFFF);
    wr(12'h3FC, 32'hFFFF_FFFF);
    wr(12'h804, 32'hFFFF_FFFF);
    wr(12'h002, 32'hFFFF_FFFF);
    rd_chk("R12 read 0x010", 12'h010, 0);
    rd_chk("R12 read 0x41C", 12'h41C, 0);
    rd_chk("R12 read 0x880", 12'h880, 0);
    rd_chk("R12 status untouched", 12'h000, 0);
    rd_chk("R12 enable untouched", 12'h004, 0);
    rd_chk("R12 syndrome untouched", syn_addr(0, 0), 0);
    chk("R12 no job started", {24'd0, job_valid}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_syndrome_and_result();
    t_ignore();
    t_w1c();
    t_set_wins();
    t_page();
    t_continuous();
    t_irq();
    t_config();
    t_unlisted();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule